// File: doc/BRIEF.md
# Interleaved Converter Offset and Gain Corrector

This block sits behind a bank of time-interleaved converter cores whose sample words have been merged into one time-ordered stream. Every word carries the index of the core that produced it. Left uncorrected, a per-core offset makes consecutive samples alternate high and low. A per-core gain mismatch gives an error whose sign flips as the signal crosses midscale. The block removes both mismatches in the stream without stopping it.

For each core the block keeps a sliding window of that core's last 2^K samples. From this window it derives two estimates. The offset is the mean of the raw samples. The magnitude is the mean absolute value once the offset has been removed. The gain factor for a core compares the average magnitude across all cores with that core's own magnitude. Each incoming word has its core's offset subtracted, is multiplied by its core's factor, and is then rounded and saturated. Holding the freeze input stops all estimation, which gives a one-time (foreground) calibration. Leaving freeze low keeps estimation running continuously (background). In both cases the correction is still applied.

Top module: `ilv_corrector`

## Requirements
- R1: Out of reset, outValid is low, every offset estimate is 0 and every gain factor is 32768 (1.0 in unsigned Q1.15).
- R2: Each cycle with inValid high produces exactly one cycle of outValid two clock edges later; no other cycle produces outValid.
- R3: The offset estimate of core c is floor(S/2^K), where S is the sum of that core's last 2^K absorbed raw samples and window slots not yet filled count as 0. It appears on estOffset bits [c*W +: W] as a signed value one edge after the sample is absorbed.
- R4: Each absorbed sample x of core c adds |x - off_c| to that core's magnitude window, using the offset estimate from before this sample. Let mag_c = floor(window sum/2^K) and avg = floor(sum over cores of mag_c / N). The gain factor g_c is 32768 if mag_c is 0, and otherwise min(floor(avg*32768/mag_c), 65535). It appears unsigned on estGain bits [c*16 +: 16].
- R5: The corrected output for input x of core c is floor(((x - off_c)*g_c + 16384)/32768), using the estimates in force in the cycle x is presented.
- R6: A corrected value above 2^(W-1)-1 is output as 2^(W-1)-1, and one below -2^(W-1) is output as -2^(W-1).
- R7: While freeze is high no sample is absorbed: all estimates hold their values, and correction continues to use them.
- R8: A sample tagged for core c changes only core c's windows; the other cores' offsets do not change.
- R9: The correction never inverts the sign: a positive offset-removed value never gives a negative output, and a negative one never gives a positive output.
- R10: The core is selected by inCore alone. Words need not arrive in round-robin order, and idle cycles between words are allowed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Input word present this cycle |
| inCore | input | clog2(N) | Index of the core that produced the word |
| inSample | input | W | Signed input sample |
| freeze | input | 1 | High: hold all estimates |
| outValid | output | 1 | Corrected word present |
| outSample | output | W | Signed corrected sample |
| estOffset | output | N*W | Per-core signed offset estimates |
| estGain | output | N*16 | Per-core unsigned Q1.15 gain factors |

## Verification
A corrected word is due on the second edge after its input edge. The estimates for a word move on the first edge, so they are visible one cycle after the word is driven. The bench drives inputs on falling edges and keeps a two-deep queue of predicted outputs, so each output check on a falling edge compares against the word driven two cycles earlier. The estimate checks on each falling edge are made against the model state before the word being driven in that cycle is absorbed. This covers round-robin and random core order, idle gaps, a frozen stretch with changed offsets, and full-scale inputs that force saturation.

// File: rtl/ilv_corrector_pkg.sv
package ilv_corrector_pkg;
  localparam int GAIN_W = 16;
  localparam int FRAC_W = 15;

  typedef struct packed {
    logic absorb;
    logic load1;
    logic load2;
  } strobes_t;
endpackage

// File: rtl/ilv_corrector_ctrl.sv
module ilv_corrector_ctrl
  import ilv_corrector_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     inValid,
  input  logic     freeze,
  output strobes_t st,
  output logic     outValid
);
  logic v1, v2;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      v1 <= 1'b0;
      v2 <= 1'b0;
    end else begin
      v1 <= inValid;
      v2 <= v1;
    end
  end

  always_comb begin
    st.absorb = inValid & ~freeze;
    st.load1  = inValid;
    st.load2  = v1;
  end

  assign outValid = v2;

  // R2
  latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> $past(inValid, 2));
endmodule

// File: rtl/ilv_corrector_dp.sv
module ilv_corrector_dp
  import ilv_corrector_pkg::*;
#(
  parameter int N = 4,
  parameter int W = 16,
  parameter int K = 4,
  localparam int CW = (N > 1) ? $clog2(N) : 1
)(
  input  logic                clk,
  input  logic                rstN,
  input  strobes_t            st,
  input  logic [CW-1:0]       inCore,
  input  logic signed [W-1:0] inSample,
  output logic signed [W-1:0] outSample,
  output logic [N*W-1:0]      estOffset,
  output logic [N*GAIN_W-1:0] estGain
);
  localparam int D    = 1 << K;
  localparam int NLOG = (N > 1) ? $clog2(N) : 0;
  localparam int PW   = W + GAIN_W + 2;
  localparam int QW   = W + FRAC_W + 1;
  localparam logic signed [PW-1:0] HALF = PW'(1) <<< (FRAC_W - 1);
  localparam logic [GAIN_W-1:0] ONE = GAIN_W'(1) << FRAC_W;

  logic signed [W-1:0]   offEst  [N];
  logic [W:0]            magEst  [N];
  logic [GAIN_W-1:0]     gainEst [N];
  logic [W+NLOG:0]       magTotal;
  logic [W:0]            magAvg;
  logic signed [W-1:0]   offSel;
  logic signed [W:0]     dIn;
  logic [W:0]            absIn;

  function automatic logic [GAIN_W-1:0] gainCalc(input logic [W:0] avgV, input logic [W:0] magV);
    logic [QW-1:0] num, q;
    num = {avgV, FRAC_W'(0)};
    q   = '0;
    if (magV == '0) return ONE;
    q = num / QW'(magV);
    if (q > QW'({GAIN_W{1'b1}})) return '1;
    return q[GAIN_W-1:0];
  endfunction

  assign offSel = offEst[inCore];
  assign dIn    = (W+1)'(inSample) - (W+1)'(offSel);
  assign absIn  = dIn[W] ? (W+1)'(-dIn) : (W+1)'(dIn);

  for (genvar c = 0; c < N; c++) begin : g_core
    logic signed [W-1:0] histRaw [D];
    logic [W:0]          histAbs [D];
    logic signed [W+K-1:0] sumRaw;
    logic [W+K:0]          sumAbs;
    logic hit;

    assign hit = st.absorb && (inCore == CW'(c));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        sumRaw <= '0;
        sumAbs <= '0;
        for (int i = 0; i < D; i++) begin
          histRaw[i] <= '0;
          histAbs[i] <= '0;
        end
      end else if (hit) begin
        sumRaw <= sumRaw + (W+K)'(inSample) - (W+K)'(histRaw[D-1]);
        sumAbs <= sumAbs + (W+K+1)'(absIn) - (W+K+1)'(histAbs[D-1]);
        histRaw[0] <= inSample;
        histAbs[0] <= absIn;
        for (int i = 1; i < D; i++) begin
          histRaw[i] <= histRaw[i-1];
          histAbs[i] <= histAbs[i-1];
        end
      end
    end

    assign offEst[c]  = W'(sumRaw >>> K);
    assign magEst[c]  = (W+1)'(sumAbs >> K);
    assign gainEst[c] = gainCalc(magAvg, magEst[c]);
    assign estOffset[c*W +: W]          = offEst[c];
    assign estGain[c*GAIN_W +: GAIN_W]  = gainEst[c];
  end

  always_comb begin
    magTotal = '0;
    for (int c = 0; c < N; c++) magTotal = magTotal + (W+NLOG+1)'(magEst[c]);
    magAvg = (W+1)'(magTotal >> NLOG);
  end

  // pipeline: stage 1 holds the offset-removed value and its factor
  logic signed [W:0]     d1;
  logic [GAIN_W-1:0]     g1;
  logic signed [PW-1:0]  prod, shifted;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      d1 <= '0;
      g1 <= ONE;
    end else if (st.load1) begin
      d1 <= dIn;
      g1 <= gainEst[inCore];
    end
  end

  always_comb begin
    prod    = PW'(d1) * $signed({1'b0, g1});
    shifted = (prod + HALF) >>> FRAC_W;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outSample <= '0;
    end else if (st.load2) begin
      if (!shifted[PW-1] && (shifted[PW-2:W-1] != '0))
        outSample <= {1'b0, {(W-1){1'b1}}};
      else if (shifted[PW-1] && (shifted[PW-2:W-1] != '1))
        outSample <= {1'b1, {(W-1){1'b0}}};
      else
        outSample <= shifted[W-1:0];
    end
  end

  // R7
  freeze_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !st.absorb |=> ($stable(estOffset) && $stable(estGain)));

  // R9
  sign_pos_chk: assert property (@(posedge clk) disable iff (!rstN)
    (st.load2 && d1 > 0) |=> !outSample[W-1]);

  // R9
  sign_neg_chk: assert property (@(posedge clk) disable iff (!rstN)
    (st.load2 && d1 < 0) |=> (outSample[W-1] || outSample == '0));

  // R5
  unity_chk: assert property (@(posedge clk) disable iff (!rstN)
    (st.load2 && g1 == ONE && d1[W] == d1[W-1]) |=> (outSample == $past(d1[W-1:0])));
endmodule

// File: rtl/ilv_corrector.sv
module ilv_corrector
  import ilv_corrector_pkg::*;
#(
  parameter int N = 4,
  parameter int W = 16,
  parameter int K = 4,
  localparam int CW = (N > 1) ? $clog2(N) : 1
)(
  input  logic                clk,
  input  logic                rstN,
  input  logic                inValid,
  input  logic [CW-1:0]       inCore,
  input  logic signed [W-1:0] inSample,
  input  logic                freeze,
  output logic                outValid,
  output logic signed [W-1:0] outSample,
  output logic [N*W-1:0]      estOffset,
  output logic [N*GAIN_W-1:0] estGain
);
  strobes_t st;

  ilv_corrector_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .freeze(freeze),
    .st(st), .outValid(outValid)
  );

  ilv_corrector_dp #(.N(N), .W(W), .K(K)) u_dp (
    .clk(clk), .rstN(rstN), .st(st), .inCore(inCore), .inSample(inSample),
    .outSample(outSample), .estOffset(estOffset), .estGain(estGain)
  );
endmodule

// File: tb/ilv_corrector_tb.sv
module ilv_corrector_tb;
  localparam int N = 4;
  localparam int W = 16;
  localparam int K = 4;
  localparam int D = 1 << K;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0;
  logic [1:0] inCore = '0;
  logic signed [W-1:0] inSample = '0;
  logic freeze = 1'b0;
  logic outValid;
  logic signed [W-1:0] outSample;
  logic [N*W-1:0] estOffset;
  logic [N*16-1:0] estGain;

  always #2 clk = ~clk;

  ilv_corrector #(.N(N), .W(W), .K(K)) u_dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inCore(inCore), .inSample(inSample),
    .freeze(freeze), .outValid(outValid), .outSample(outSample),
    .estOffset(estOffset), .estGain(estGain)
  );

  int nChecks = 0;
  int nErr = 0;
  bit done = 0;

  int mHist [N][D];
  int mHistA [N][D];
  int mSum [N];
  int mSumA [N];
  bit p1v, p2v, p1sat, p2sat;
  int p1s, p2s;

  task automatic chk(string tag, longint act, longint exp);
    nChecks++;
    if (act != exp) begin
      nErr++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int mOff(int c);
    return mSum[c] >>> K;
  endfunction

  function automatic int mMag(int c);
    return mSumA[c] >>> K;
  endfunction

  function automatic int mGain(int c);
    int tot = 0;
    int avg, m;
    longint q;
    for (int i = 0; i < N; i++) tot += mMag(i);
    avg = tot >>> 2;
    m = mMag(c);
    if (m == 0) return 32768;
    q = (longint'(avg) * 32768) / m;
    if (q > 65535) return 65535;
    return int'(q);
  endfunction

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", nErr, nChecks);
      $finish;
    end
  endtask

  // one cycle: check outputs and estimates, then present the next word
  task automatic step(bit v, int c, int x, bit fz, string estTag);
    longint p;
    int d, a;
    @(negedge clk);
    chk("R2 outValid", outValid, p2v);
    if (p2v) chk(p2sat ? "R6 saturated output" : "R5 corrected output", outSample, p2s);
    for (int i = 0; i < N; i++) begin
      chk({estTag, " offset"}, $signed(estOffset[i*W +: W]), mOff(i));
      chk({estTag, " R4 gain"}, estGain[i*16 +: 16], mGain(i));
    end
    p2v = p1v; p2s = p1s; p2sat = p1sat;
    p1v = v; p1sat = 0; p1s = 0;
    if (v) begin
      d = x - mOff(c);
      p = (longint'(d) * mGain(c) + 16384) >>> 15;
      if (p > 32767) begin p = 32767; p1sat = 1; end
      else if (p < -32768) begin p = -32768; p1sat = 1; end
      p1s = int'(p);
      if (!fz) begin
        a = (d < 0) ? -d : d;
        mSum[c]  += x - mHist[c][D-1];
        mSumA[c] += a - mHistA[c][D-1];
        for (int i = D-1; i > 0; i--) begin
          mHist[c][i] = mHist[c][i-1];
          mHistA[c][i] = mHistA[c][i-1];
        end
        mHist[c][0] = x;
        mHistA[c][0] = a;
      end
    end
    inValid = v;
    inCore = 2'(c);
    inSample = W'(x);
    freeze = fz;
  endtask

  function automatic int clampS(int x);
    if (x > 32767) return 32767;
    if (x < -32768) return -32768;
    return x;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    nErr++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    summary();
  end

  initial begin
    int offs [N] = '{-900, 300, 1200, -50};
    int amp  [N] = '{8000, 9000, 7000, 10000};
    int c;
    void'($urandom(32'd1234));
    for (int i = 0; i < N; i++) begin
      mSum[i] = 0; mSumA[i] = 0;
      for (int j = 0; j < D; j++) begin mHist[i][j] = 0; mHistA[i][j] = 0; end
    end
    p1v = 0; p2v = 0; p1s = 0; p2s = 0; p1sat = 0; p2sat = 0;
    repeat (3) @(posedge clk);
    rstN = 1'b1;

    // R1: reset state
    @(negedge clk);
    chk("R1 outValid", outValid, 0);
    for (int i = 0; i < N; i++) begin
      chk("R1 offset", estOffset[i*W +: W], 0);
      chk("R1 gain", estGain[i*16 +: 16], 32768);
    end

    // R3 R4 R5 R8: round robin with idle gaps
    c = 0;
    for (int n = 0; n < 400; n++) begin
      bit v = ($urandom % 5) != 0;
      int x = offs[c] + int'($urandom % (2*amp[c] + 1)) - amp[c];
      step(v, c, x, 0, "R3 R8");
      if (v) c = (c + 1) % N;
    end

    // R10: arbitrary core order
    for (int n = 0; n < 300; n++) begin
      int cc = int'($urandom % N);
      int x = offs[cc] + int'($urandom % (2*amp[cc] + 1)) - amp[cc];
      step(($urandom % 4) != 0, cc, x, 0, "R10 R3");
    end

    // R7: frozen estimation, shifted offsets must not leak in
    for (int n = 0; n < 200; n++) begin
      int cc = n % N;
      int x = clampS(offs[cc] + 3000 + int'($urandom % (2*amp[cc] + 1)) - amp[cc]);
      step(1, cc, x, 1, "R7");
    end

    // R6: full-scale extremes drive the product past the limits
    for (int n = 0; n < 300; n++) begin
      int cc = n % N;
      int r = int'($urandom % 4);
      int x = (r == 0) ? 32767 : (r == 1) ? -32768 : (r == 2) ? 32000 : -32000;
      if (cc == 0) x = x / 8;
      step(1, cc, x, 0, "R6 R3");
    end

    // directed: single word then idle, latency of exactly two edges
    step(1, 2, 12345, 0, "R2");
    for (int n = 0; n < 4; n++) step(0, 0, 0, 0, "R2");
    summary();
  end
endmodule